// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation analog-to-digital converter. It drives a trial code to an external DAC, reads back a single comparator bit, and settles the result one bit per step, starting at the most significant bit. An external comparator, DAC and reference finish the converter. The bench replaces them with a threshold compare.

A convert command pulse controls each conversion. The command is synchronized to the system clock first. Its rising edge clears the outputs and aborts any conversion in progress. Its falling edge starts a new conversion. Bit steps are paced by a step clock taken from an internal divider or from an external clock pin, and the chosen step clock is also driven out.

While the conversion runs, each decided bit is sent out at once as NRZ serial data, together with its complement. A short-cycle input stops the sequence after fewer bits. A format input turns the offset-binary parallel result into two's complement by inverting the MSB. An end-of-conversion flag is high for the whole conversion.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, dac_o and par_o are 0, eoc_o is 0, ser_o is 0, ser_n_o is 1 and clk_o is 0.
- R2: A rising edge on conv_i takes effect on the third rising clock edge after it is applied. On that edge dac_o, the parallel result (par_o with twos_i low), eoc_o and ser_o all become 0, and ser_n_o becomes 1.
- R3: A falling edge on conv_i takes effect on the third rising clock edge after it is applied. On that edge eoc_o rises and dac_o holds only its MSB set, as the first trial.
- R4: At each step the bit on trial is kept when cmp_i is 0 (DAC not above the input) and cleared when cmp_i is 1. The next lower bit is then set as the new trial. For an ideal comparator the final parallel code equals the input with the undecided low bits zeroed.
- R5: eoc_o stays high until the step that decides the last bit and falls on that same edge. The number of steps taken equals the effective bit count.
- R6: short_i, sampled at the start, sets the effective bit count. The values 0 and anything above RES mean RES bits. The bits below the cut point read 0 on par_o.
- R7: On every step ser_o shows the bit just decided and ser_n_o shows its complement. Both hold until the next step or the next clear, including after eoc_o has fallen.
- R8: With twos_i high, the MSB of par_o is inverted (two's complement). With twos_i low, par_o is straight or offset binary.
- R9: With use_ext_i low, steps come from an internal divider with a period of 2*HALF_DIV clock cycles. With use_ext_i high, steps come from rising edges of ext_clk_i after a two-flop synchronizer. clk_o is the selected step clock, delayed by one register, and a step happens when clk_o rises.
- R10: A new convert command during a conversion aborts it, and the conversion started on the new falling edge gives a correct result.
- R11: While no conversion runs, steps and changes on cmp_i leave dac_o, par_o and ser_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert command pulse (asynchronous) |
| use_ext_i | input | 1 | 1 selects the external step clock |
| ext_clk_i | input | 1 | External step clock (asynchronous) |
| clk_o | output | 1 | Selected step clock, registered |
| cmp_i | input | 1 | Comparator result: 1 when the DAC output is above the input |
| short_i | input | CW | Requested bit count; 0 or above RES means RES |
| twos_i | input | 1 | 1 inverts the MSB of par_o |
| dac_o | output | RES | Trial code to the DAC |
| par_o | output | RES | Parallel result |
| eoc_o | output | 1 | End of conversion flag, high while converting |
| ser_o | output | 1 | NRZ serial bit as each bit is decided |
| ser_n_o | output | 1 | Complement of ser_o |

## Verification
Edges on the convert command act on the third rising edge after they are driven, so the bench samples three falling edges later. The first trial code and the cleared outputs are checked there. A step, and with it the decided serial bit, shows up at the first falling edge after clk_o is seen to rise. The bench checks ser_o at that point against the input bit at the current position and counts steps until eoc_o is seen low. The final parallel code is compared once eoc_o has dropped, and again after ten more cycles with the comparator input moved, to confirm that nothing changes while idle.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Effective number of bits for a short-cycle request.
  function automatic int eff_bits(input int req, input int res);
    if (req == 0 || req > res) return res;
    return req;
  endfunction

  // Index of the last bit decided in a conversion of n bits.
  function automatic int last_index(input int n, input int res);
    return res - n;
  endfunction

  // Trial bit is kept when the DAC is not above the input.
  function automatic logic keep_bit(input logic dac_above);
    return ~dac_above;
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_step_gen.sv
module sar_step_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext_i,
  input  logic ext_lvl_i,
  output logic clk_o,
  output logic step_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          int_lvl_q;
  logic          sel_lvl;
  logic          clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      int_lvl_q <= 1'b0;
    end else if (div_q == DW'(HALF_DIV - 1)) begin
      div_q     <= '0;
      int_lvl_q <= ~int_lvl_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign sel_lvl = use_ext_i ? ext_lvl_i : int_lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= sel_lvl;
  end

  assign clk_o  = clk_q;
  assign step_o = sel_lvl & ~clk_q;
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int RES = 12,
  parameter int CW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           start_i,
  input  logic           step_i,
  input  logic           cmp_i,
  input  logic [CW-1:0]  short_i,
  output logic [RES-1:0] dac_o,
  output logic [RES-1:0] res_o,
  output logic           busy_o,
  output logic           ser_o,
  output logic           ser_n_o
);
  localparam int IW = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] dac_q, res_q;
  logic [IW-1:0]  idx_q, last_q, last_calc, idx_m1;
  logic           busy_q, ser_q, ser_n_q;
  logic           bit_val;
  logic           at_last;

  assign last_calc = IW'(last_index(eff_bits(int'(short_i), RES), RES));
  assign idx_m1    = idx_q - 1'b1;
  assign bit_val   = keep_bit(cmp_i);
  assign at_last   = (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q   <= '0;
      res_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      busy_q  <= 1'b0;
      ser_q   <= 1'b0;
      ser_n_q <= 1'b1;
    end else if (clear_i) begin
      dac_q   <= '0;
      res_q   <= '0;
      busy_q  <= 1'b0;
      ser_q   <= 1'b0;
      ser_n_q <= 1'b1;
    end else if (start_i) begin
      dac_q  <= MSB_ONLY;
      res_q  <= '0;
      idx_q  <= IW'(RES - 1);
      last_q <= last_calc;
      busy_q <= 1'b1;
    end else if (step_i && busy_q) begin
      dac_q[idx_q] <= bit_val;
      res_q[idx_q] <= bit_val;
      ser_q        <= bit_val;
      ser_n_q      <= ~bit_val;
      if (at_last) begin
        busy_q <= 1'b0;
      end else begin
        dac_q[idx_m1] <= 1'b1;
        idx_q         <= idx_m1;
      end
    end
  end

  assign dac_o   = dac_q;
  assign res_o   = res_q;
  assign busy_o  = busy_q;
  assign ser_o   = ser_q;
  assign ser_n_o = ser_n_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter  int RES      = 12,
  parameter  int HALF_DIV = 4,
  localparam int CW       = $clog2(RES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_i,
  input  logic           use_ext_i,
  input  logic           ext_clk_i,
  output logic           clk_o,
  input  logic           cmp_i,
  input  logic [CW-1:0]  short_i,
  input  logic           twos_i,
  output logic [RES-1:0] dac_o,
  output logic [RES-1:0] par_o,
  output logic           eoc_o,
  output logic           ser_o,
  output logic           ser_n_o
);
  logic conv_s, conv_prev_q;
  logic conv_rise, conv_fall;
  logic ext_s;
  logic step;
  logic [RES-1:0] res_raw;

  sar_sync #(.STAGES(2)) u_conv_sync (
    .clk(clk), .rst_n(rst_n), .d_i(conv_i), .q_o(conv_s)
  );

  sar_sync #(.STAGES(2)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_clk_i), .q_o(ext_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_prev_q <= 1'b0;
    else        conv_prev_q <= conv_s;
  end

  assign conv_rise = conv_s & ~conv_prev_q;
  assign conv_fall = ~conv_s & conv_prev_q;

  sar_step_gen #(.HALF_DIV(HALF_DIV)) u_step (
    .clk(clk), .rst_n(rst_n), .use_ext_i(use_ext_i),
    .ext_lvl_i(ext_s), .clk_o(clk_o), .step_o(step)
  );

  sar_core #(.RES(RES), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .clear_i(conv_rise), .start_i(conv_fall),
    .step_i(step), .cmp_i(cmp_i), .short_i(short_i), .dac_o(dac_o),
    .res_o(res_raw), .busy_o(eoc_o), .ser_o(ser_o), .ser_n_o(ser_n_o)
  );

  assign par_o = {res_raw[RES-1] ^ twos_i, res_raw[RES-2:0]};
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_rise,
  input logic           conv_fall,
  input logic           step,
  input logic           eoc_o,
  input logic [RES-1:0] dac_o,
  input logic           ser_o,
  input logic           ser_n_o
);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise |=> (dac_o == '0) && !eoc_o && !ser_o && ser_n_o);

  p_start_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fall |=> eoc_o);

  p_start_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fall |=> ($countones(dac_o) == 1) && dac_o[RES-1]);

  p_eoc_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_o) |-> ($past(step) || $past(conv_rise)));

  p_ser_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !conv_rise) |=> $stable(ser_o));

  p_ser_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_o != ser_n_o);

  p_step_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

  p_idle_dac_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_o && !conv_rise && !conv_fall) |=> $stable(dac_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .conv_fall(conv_fall),
  .step(step), .eoc_o(eoc_o), .dac_o(dac_o), .ser_o(ser_o), .ser_n_o(ser_n_o)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  localparam int RES  = 12;
  localparam int HDIV = 4;
  localparam int CW   = $clog2(RES + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_i = 1'b0, use_ext_i = 1'b0, ext_clk_i = 1'b0, twos_i = 1'b0;
  logic [CW-1:0]  short_i = '0;
  logic [RES-1:0] vin = '0;
  logic clk_o, eoc_o, ser_o, ser_n_o, cmp_i;
  logic [RES-1:0] dac_o, par_o;
  int errors = 0, checks = 0, cyc = 0, ext_div = 0;

  always #2 clk = ~clk;

  assign cmp_i = (dac_o > vin);

  always @(negedge clk) begin
    ext_div <= (ext_div == 2) ? 0 : ext_div + 1;
    if (ext_div == 2) ext_clk_i <= ~ext_clk_i;
  end

  sar_conv_ctrl #(.RES(RES), .HALF_DIV(HDIV)) i_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .use_ext_i(use_ext_i),
    .ext_clk_i(ext_clk_i), .clk_o(clk_o), .cmp_i(cmp_i), .short_i(short_i),
    .twos_i(twos_i), .dac_o(dac_o), .par_o(par_o), .eoc_o(eoc_o),
    .ser_o(ser_o), .ser_n_o(ser_n_o)
  );

  function automatic int n_of(input int req);
    return (req >= 1 && req <= RES) ? req : RES;
  endfunction

  function automatic logic [RES-1:0] want(input logic [RES-1:0] v, input int req, input bit tw);
    logic [RES-1:0] m;
    m = ~((RES'(1) << (RES - n_of(req))) - RES'(1));
    return (v & m) ^ (tw ? RES'(1) << (RES - 1) : RES'(0));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic pulse_high();
    @(negedge clk) conv_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_low();
    conv_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Steps, serial bits and the final code of one conversion (already started).
  task automatic follow(input logic [RES-1:0] v, input int req, input bit tw);
    int k = 0, guard = 0;
    logic pe = 1'b1, pc;
    logic [RES-1:0] hold;
    logic hs;
    pc = clk_o;
    while (guard < 2000) begin
      @(negedge clk);
      guard++;
      if (clk_o && !pc && pe) begin
        k++;
        check(ser_o == v[RES-k], "R7 serial bit", ser_o, v[RES-k]);
        check(ser_n_o == !v[RES-k], "R7 serial complement", ser_n_o, !v[RES-k]);
      end
      if (!eoc_o) break;
      pe = eoc_o;
      pc = clk_o;
    end
    check(k == n_of(req), "R5 R6 step count", k, n_of(req));
    check(par_o == want(v, req, tw), "R4 R6 R8 result", par_o, want(v, req, tw));
    hold = par_o;
    hs = ser_o;
    vin = ~v;
    repeat (10) @(negedge clk);
    check(par_o == hold && ser_o == hs, "R11 R7 idle hold", par_o, hold);
  endtask

  task automatic convert(input logic [RES-1:0] v, input int req, input bit tw, input bit ex);
    vin = v;
    short_i = CW'(req);
    twos_i = tw;
    use_ext_i = ex;
    pulse_high();
    release_low();
    check(eoc_o == 1'b1, "R3 eoc high", eoc_o, 1);
    check(dac_o == {1'b1, {(RES-1){1'b0}}}, "R3 first trial", dac_o, 1 << (RES-1));
    follow(v, req, tw);
  endtask

  initial begin
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    check(dac_o == 0 && par_o == 0, "R1 codes", dac_o, 0);
    check(!eoc_o && !ser_o && ser_n_o && !clk_o, "R1 flags", {eoc_o, ser_o, ser_n_o, clk_o}, 4'b0010);
    rst_n = 1'b1;

    // R9: internal step period.
    begin
      int t0 = 0, t1 = 0; logic p;
      p = clk_o;
      while (t1 == 0) begin
        @(negedge clk);
        if (clk_o && !p) begin if (t0 == 0) t0 = cyc; else t1 = cyc; end
        p = clk_o;
      end
      check(t1 - t0 == 2 * HDIV, "R9 internal period", t1 - t0, 2 * HDIV);
      use_ext_i = 1'b1;
      t0 = 0; t1 = 0;
      repeat (8) @(negedge clk);
      p = clk_o;
      while (t1 == 0) begin
        @(negedge clk);
        if (clk_o && !p) begin if (t0 == 0) t0 = cyc; else t1 = cyc; end
        p = clk_o;
      end
      check(t1 - t0 == 6, "R9 external period", t1 - t0, 6);
    end

    convert(12'h000, 0, 0, 0);
    convert(12'hFFF, 0, 0, 1);
    convert(12'h800, 12, 1, 0);
    convert(12'h7FF, 1, 0, 0);
    convert(12'hA5C, 10, 0, 1);
    convert(12'h3C7, 13, 1, 0);
    convert(12'h001, 15, 0, 0);

    // R2 and R10: abort mid conversion, then restart.
    vin = 12'h9B3; short_i = '0; twos_i = 1'b0; use_ext_i = 1'b0;
    pulse_high();
    release_low();
    repeat (20) @(negedge clk);
    check(eoc_o == 1'b1, "R10 still converting", eoc_o, 1);
    pulse_high();
    check(dac_o == 0 && par_o == 0, "R2 clear codes", dac_o, 0);
    check(!eoc_o && !ser_o && ser_n_o, "R2 clear flags", {eoc_o, ser_o, ser_n_o}, 3'b001);
    vin = 12'h46E;
    release_low();
    check(eoc_o == 1'b1, "R10 restart", eoc_o, 1);
    follow(12'h46E, 0, 0);

    for (int i = 0; i < 20; i++) begin
      logic [RES-1:0] rv;
      rv = RES'($urandom);
      convert(rv, int'($urandom % 16), 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule